// File: doc/BRIEF.md
# Wake-on-receive UART receiver

This block is one asynchronous serial receive channel that keeps working while the rest of the system sits in a low-power stop state. A power controller drives `stop_req`. While it is high and wake-on-receive is armed, the block watches the serial line for a falling edge. When it sees one, it enters a snooze state, raises `clk_req` to ask for its clock, and decodes the frame on its own.

A frame consists of a start bit, `DATA_W` data bits sent LSB first, an optional parity bit and one stop bit. Every bit lasts `OVS` oversampling ticks and is sampled at mid-bit. What happens after the frame depends on its outcome:
- A good frame is stored in the data register and raises `rx_irq`, which wakes the system.
- When error-suppress is selected, a frame with an error is dropped silently and the block falls back to waiting in stop.

Received data leaves the block through a valid/ready register. `rx_valid` stays high and `rx_data` stays stable until a cycle with `rx_ready` high takes the word. The serial line cannot be stalled, so back-pressure has only one effect: a frame that completes while the register is still full (and is not being read in that cycle) counts as an overrun.

Top module: `wake_uart_rx`

## Requirements
- R1: After reset, `rx_valid`, `flags`, `busy`, `clk_req`, `snoozing`, `rx_irq` and `err_irq` are all 0, and the block is in run mode.
- R2: With `stop_req`, `snooze_en` and `fast_clk_sel` all high, a falling edge on `rxd` raises `snoozing` and `clk_req` within 4 cycles, and both stay high while the frame is received.
- R3: If `fast_clk_sel` or `snooze_en` is low while `stop_req` is high, a falling edge has no effect:
  - `clk_req` stays 0.
  - Nothing is stored.
  - No interrupt is raised.
- R4: Frame format and good-frame handling:
  - The frame is a start bit (0), `DATA_W` data bits LSB first, a parity bit when `parity_en` is 1, and a stop bit (1). Each bit lasts `OVS` ticks.
  - Parity is even when `parity_odd` is 0 and odd when it is 1, counted over the data bits and the parity bit together.
  - A good frame is stored in `rx_data`, sets `rx_valid` and pulses `rx_irq` for one cycle.
  - If the frame was received in snooze, `clk_req` and `snoozing` then drop.
- R5: `busy` is high from start-bit detection until the cycle in which the frame is stored.
- R6: A low pulse on `rxd` shorter than half a bit starts no transfer:
  - The block stays in snooze with `clk_req` high.
  - `busy` returns to 0.
  - Nothing is stored.
- R7: With `err_quiet` high, a frame with a parity, framing or overrun error has no visible result:
  - It changes no flag.
  - It raises neither interrupt.
  - It leaves `rx_data` and `rx_valid` unchanged.
  - If it arrived in snooze, the block returns to stop with `clk_req` low.
- R8: With `err_quiet` low, an erroneous frame is still stored and pulses `rx_irq`, and it sets its flag bits (bit0 parity, bit1 framing, bit2 overrun). `err_irq` pulses only if `err_irq_en` is 1.
- R9: Overrun handling:
  - A frame that completes while `rx_valid` is high and `rx_ready` is low sets `flags[2]` (when `err_quiet` is low).
  - In that case the new data replaces the old.
- R10: Writing 1 to a bit of `flag_clr` clears the matching flag bit and leaves the other bits unchanged.
- R11: `rx_data` stays stable while `rx_valid` is high and no handshake has taken place. `rx_valid` falls in the cycle after `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling tick, `OVS` per bit |
| rxd | input | 1 | Serial receive line, idle high |
| stop_req | input | 1 | System stop state from power controller |
| snooze_en | input | 1 | Arms wake-on-receive in stop |
| fast_clk_sel | input | 1 | Fast internal clock selected; snooze blocked when low |
| err_quiet | input | 1 | Error-suppress select |
| err_irq_en | input | 1 | Error interrupt enable |
| parity_en | input | 1 | Frame carries a parity bit |
| parity_odd | input | 1 | 1 odd parity, 0 even parity |
| rx_ready | input | 1 | Consumer takes the data word |
| flag_clr | input | 3 | Write-one-to-clear for `flags` |
| rx_data | output | DATA_W | Received data word |
| rx_valid | output | 1 | Data register holds an unread word |
| flags | output | 3 | Sticky error flags: bit0 parity, bit1 framing, bit2 overrun |
| rx_irq | output | 1 | One-cycle receive-complete pulse |
| err_irq | output | 1 | One-cycle error pulse |
| busy | output | 1 | Transfer in progress |
| clk_req | output | 1 | Clock request while snoozing |
| snoozing | output | 1 | Block is in the snooze state |

## Verification
The stop bit is sampled in its middle, and the data register, the flags and both interrupt pulses change one cycle after that sample. The bench therefore reads them once it has finished driving the whole stop bit plus a few idle cycles, and it counts the one-cycle interrupt pulses on every falling clock edge. `clk_req` and `snoozing` follow a stop-state edge after at most four cycles, and `busy` stays high for the whole frame, so those outputs are sampled in the middle of a data bit. The effect of a short pulse is judged about forty cycles after it, well after the mid-start check has aborted the transfer.

// File: rtl/wur_pkg.sv
package wur_pkg;
  typedef enum logic [1:0] {P_RUN, P_STOP, P_SNOOZE, P_WAKE} pwr_t;
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rx_t;
  localparam int FL_PAR = 0;
  localparam int FL_FRM = 1;
  localparam int FL_OVR = 2;
  localparam int FL_W   = 3;
endpackage

// File: rtl/wur_sync.sv
module wur_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic rxd_s,
  output logic fall
);
  logic m0, prev;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m0 <= 1'b1; rxd_s <= 1'b1; prev <= 1'b1;
    end else begin
      m0 <= rxd; rxd_s <= m0; prev <= rxd_s;
    end
  end
  assign fall = prev & ~rxd_s;
endmodule

// File: rtl/wur_frame.sv
module wur_frame import wur_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [DATA_W-1:0] fdata,
  output logic              perr,
  output logic              ferr,
  output logic              busy
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] CMAX = CW'(OVS - 1);
  localparam logic [CW-1:0] CHALF = CW'(OVS / 2 - 1);
  localparam logic [BW-1:0] BLAST = BW'(DATA_W - 1);

  rx_t st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic par_bit;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      st <= R_IDLE; cnt <= '0; bitn <= '0; fdata <= '0;
      par_bit <= 1'b0; done <= 1'b0; perr <= 1'b0; ferr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          R_IDLE: if (!rxd) begin st <= R_START; cnt <= '0; end
          R_START: begin
            if (cnt == CHALF) begin
              cnt <= '0; bitn <= '0;
              st <= rxd ? R_IDLE : R_DATA;
            end else cnt <= cnt + 1'b1;
          end
          R_DATA: begin
            if (cnt == CMAX) begin
              cnt <= '0;
              fdata <= {rxd, fdata[DATA_W-1:1]};
              bitn <= bitn + 1'b1;
              if (bitn == BLAST) st <= par_en ? R_PAR : R_STOP;
            end else cnt <= cnt + 1'b1;
          end
          R_PAR: begin
            if (cnt == CMAX) begin
              cnt <= '0; par_bit <= rxd; st <= R_STOP;
            end else cnt <= cnt + 1'b1;
          end
          R_STOP: begin
            if (cnt == CMAX) begin
              cnt <= '0; st <= R_IDLE; done <= 1'b1;
              ferr <= ~rxd;
              perr <= par_en && (par_bit != ((^fdata) ^ par_odd));
            end else cnt <= cnt + 1'b1;
          end
          default: st <= R_IDLE;
        endcase
      end
    end
  end

  assign busy = (st != R_IDLE) || done;

  // R6: a high line at the mid-start check ends the transfer
  p_short_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && st == R_START && cnt == CHALF && rxd) |=> !busy);
endmodule

// File: rtl/wur_power.sv
module wur_power import wur_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic snooze_en,
  input  logic fast_clk_sel,
  input  logic fall,
  input  logic accept,
  input  logic drop,
  output logic clk_req,
  output logic snoozing,
  output logic rx_en
);
  pwr_t st;
  always_ff @(posedge clk) begin
    if (!rst_n) st <= P_RUN;
    else begin
      case (st)
        P_RUN:    if (stop_req) st <= P_STOP;
        P_STOP:   if (!stop_req) st <= P_RUN;
                  else if (fall && snooze_en && fast_clk_sel) st <= P_SNOOZE;
        P_SNOOZE: if (!stop_req) st <= P_RUN;
                  else if (accept) st <= P_WAKE;
                  else if (drop) st <= P_STOP;
        P_WAKE:   if (!stop_req) st <= P_RUN;
        default:  st <= P_RUN;
      endcase
    end
  end
  assign snoozing = (st == P_SNOOZE);
  assign clk_req  = snoozing;
  assign rx_en    = (st != P_STOP);

  // R2 / R3: snooze is entered only from stop with wake armed and fast clock
  p_entry_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snoozing) |-> $past(stop_req && snooze_en && fast_clk_sel && fall));
  // R7: a dropped frame in snooze returns to stop without clock request
  p_quiet_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snoozing && stop_req && drop) |=> !clk_req);
endmodule

// File: rtl/wur_regs.sv
module wur_regs import wur_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] fdata,
  input  logic              perr,
  input  logic              ferr,
  input  logic              err_quiet,
  input  logic              err_irq_en,
  input  logic              rx_ready,
  input  logic [FL_W-1:0]   flag_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic [FL_W-1:0]   flags,
  output logic              rx_irq,
  output logic              err_irq,
  output logic              accept,
  output logic              drop
);
  logic [FL_W-1:0] errs;
  logic any_err, taken;

  assign taken = rx_valid && rx_ready;
  always_comb begin
    errs = '0;
    errs[FL_PAR] = done && perr;
    errs[FL_FRM] = done && ferr;
    errs[FL_OVR] = done && rx_valid && !rx_ready;
  end
  assign any_err = |errs;
  assign drop    = done && err_quiet && any_err;
  assign accept  = done && !drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data <= '0; rx_valid <= 1'b0; flags <= '0;
      rx_irq <= 1'b0; err_irq <= 1'b0;
    end else begin
      rx_irq  <= accept;
      err_irq <= accept && any_err && err_irq_en;
      if (accept) begin
        rx_data <= fdata; rx_valid <= 1'b1;
      end else if (taken) rx_valid <= 1'b0;
      flags <= (flags & ~flag_clr) | (accept ? errs : '0);
    end
  end

  // R7: suppressed errors never raise a flag
  p_quiet_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_quiet && flag_clr == '0) |=> $stable(flags));
  // R8: error interrupt stays low while disabled
  p_err_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !err_irq_en |=> !err_irq);
  // R4: receive pulse always comes with valid data
  p_irq_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_valid);
  // R11: held word does not change without a handshake
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !done) |=> ($stable(rx_data) && rx_valid));
endmodule

// File: rtl/wake_uart_rx.sv
module wake_uart_rx import wur_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              stop_req,
  input  logic              snooze_en,
  input  logic              fast_clk_sel,
  input  logic              err_quiet,
  input  logic              err_irq_en,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              rx_ready,
  input  logic [2:0]        flag_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic [2:0]        flags,
  output logic              rx_irq,
  output logic              err_irq,
  output logic              busy,
  output logic              clk_req,
  output logic              snoozing
);
  logic rxd_s, fall, rx_en, done, perr, ferr, accept, drop;
  logic [DATA_W-1:0] fdata;

  wur_sync u_sync (.clk(clk), .rst_n(rst_n), .rxd(rxd), .rxd_s(rxd_s), .fall(fall));

  wur_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .rxd(rxd_s),
    .par_en(parity_en), .par_odd(parity_odd), .done(done), .fdata(fdata),
    .perr(perr), .ferr(ferr), .busy(busy));

  wur_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .done(done), .fdata(fdata), .perr(perr),
    .ferr(ferr), .err_quiet(err_quiet), .err_irq_en(err_irq_en),
    .rx_ready(rx_ready), .flag_clr(flag_clr), .rx_data(rx_data),
    .rx_valid(rx_valid), .flags(flags), .rx_irq(rx_irq), .err_irq(err_irq),
    .accept(accept), .drop(drop));

  wur_power u_power (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .snooze_en(snooze_en),
    .fast_clk_sel(fast_clk_sel), .fall(fall), .accept(accept), .drop(drop),
    .clk_req(clk_req), .snoozing(snoozing), .rx_en(rx_en));
endmodule

// File: tb/sim_wake_uart_rx.sv
`timescale 1ns/1ps
module sim_wake_uart_rx;
  localparam int OVS = 16;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, rxd = 1'b1;
  logic stop_req = 0, snooze_en = 0, fast_clk_sel = 1, err_quiet = 0, err_irq_en = 0;
  logic parity_en = 0, parity_odd = 0, rx_ready = 0;
  logic [2:0] flag_clr = 3'b0;
  logic [7:0] rx_data;
  logic rx_valid, rx_irq, err_irq, busy, clk_req, snoozing;
  logic [2:0] flags;

  int checks = 0, fails = 0, cyc = 0, rx_cnt = 0, er_cnt = 0;
  logic mid_busy, mid_clk, mid_snz;

  always #10 clk = ~clk;

  wake_uart_rx u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .stop_req(stop_req),
    .snooze_en(snooze_en), .fast_clk_sel(fast_clk_sel), .err_quiet(err_quiet),
    .err_irq_en(err_irq_en), .parity_en(parity_en), .parity_odd(parity_odd),
    .rx_ready(rx_ready), .flag_clr(flag_clr), .rx_data(rx_data), .rx_valid(rx_valid),
    .flags(flags), .rx_irq(rx_irq), .err_irq(err_irq), .busy(busy), .clk_req(clk_req),
    .snoozing(snoozing));

  always @(negedge clk) begin
    if (rx_irq) rx_cnt++;
    if (err_irq) er_cnt++;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: act %0d exp below 150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act %0h exp %0h", tag, act, exp);
    end
  endtask

  function automatic logic par_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic bit_out(input logic b);
    rxd = b;
    repeat (OVS) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    @(negedge clk);
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (OVS / 2) @(negedge clk);
      if (i == 3) begin mid_busy = busy; mid_clk = clk_req; mid_snz = snoozing; end
      repeat (OVS / 2) @(negedge clk);
    end
    if (parity_en) bit_out(par_of(d, parity_odd) ^ bad_par);
    bit_out(~bad_stop);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic take();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic clr(input logic [2:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = 3'b0;
  endtask

  initial begin
    int rc0, ec0;
    logic [7:0] d;
    void'($urandom(32'h5eed1));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", rx_valid, 0); chk("R1 flags", flags, 0); chk("R1 busy", busy, 0);
    chk("R1 clk_req", clk_req, 0); chk("R1 snooze", snoozing, 0);

    // R4 / R5 plain frame in run mode
    send(8'hA5, 0, 0);
    chk("R5 busy mid", mid_busy, 1); chk("R5 busy after", busy, 0);
    chk("R4 data", rx_data, 8'hA5); chk("R4 valid", rx_valid, 1); chk("R4 irq", rx_cnt, 1);
    repeat (10) @(negedge clk);
    chk("R11 held", rx_data, 8'hA5); chk("R11 still valid", rx_valid, 1);
    take();
    chk("R11 taken", rx_valid, 0);

    // R4 parity variants
    parity_en = 1; parity_odd = 0; send(8'h37, 0, 0);
    chk("R4 even data", rx_data, 8'h37); chk("R4 even flags", flags, 0); take();
    parity_odd = 1; send(8'h0F, 0, 0);
    chk("R4 odd data", rx_data, 8'h0F); chk("R4 odd flags", flags, 0); take();

    // R8 parity error with error interrupt enabled
    err_irq_en = 1; ec0 = er_cnt; rc0 = rx_cnt;
    send(8'h5C, 1, 0);
    chk("R8 par flag", flags, 3'b001); chk("R8 err irq", er_cnt, ec0 + 1);
    chk("R8 stored", rx_data, 8'h5C); chk("R8 rx irq", rx_cnt, rc0 + 1); take();
    clr(3'b001); chk("R10 clear par", flags, 0);
    // R8 framing error with error interrupt disabled
    err_irq_en = 0; parity_en = 0; ec0 = er_cnt;
    send(8'hC3, 0, 1);
    chk("R8 frm flag", flags, 3'b010); chk("R8 no err irq", er_cnt, ec0); take();
    rxd = 1; repeat (40) @(negedge clk);

    // R9 overrun and R10 per-bit clear
    send(8'h11, 0, 0); send(8'h22, 0, 0);
    chk("R9 ovr flag", flags, 3'b110 & 3'b100 | (flags & 3'b010)); chk("R9 new data", rx_data, 8'h22);
    clr(3'b100); chk("R10 ovr cleared others kept", flags, 3'b010);
    clr(3'b010); chk("R10 all clear", flags, 0); take();

    // R2 / R4 wake from stop
    stop_req = 1; snooze_en = 1; fast_clk_sel = 1;
    repeat (5) @(negedge clk);
    chk("R2 idle no clk_req", clk_req, 0);
    rc0 = rx_cnt;
    send(8'h6E, 0, 0);
    chk("R2 clk_req mid", mid_clk, 1); chk("R2 snooze mid", mid_snz, 1);
    chk("R4 wake data", rx_data, 8'h6E); chk("R4 wake irq", rx_cnt, rc0 + 1);
    chk("R4 wake clk_req low", clk_req, 0);
    stop_req = 0; take(); repeat (3) @(negedge clk);

    // R3 blocked entry
    stop_req = 1; fast_clk_sel = 0; repeat (4) @(negedge clk);
    rc0 = rx_cnt; send(8'h99, 0, 0);
    chk("R3 fast off clk_req", mid_clk, 0); chk("R3 fast off valid", rx_valid, 0);
    chk("R3 fast off irq", rx_cnt, rc0);
    fast_clk_sel = 1; snooze_en = 0; send(8'h98, 0, 0);
    chk("R3 armed off clk_req", mid_clk, 0); chk("R3 armed off valid", rx_valid, 0);
    snooze_en = 1; repeat (4) @(negedge clk);

    // R6 short pulse in snooze
    rxd = 0; repeat (4) @(negedge clk); rxd = 1; repeat (40) @(negedge clk);
    chk("R6 snoozing", snoozing, 1); chk("R6 clk_req", clk_req, 1);
    chk("R6 busy", busy, 0); chk("R6 valid", rx_valid, 0);
    send(8'h3C, 0, 0);
    chk("R6 later frame", rx_data, 8'h3C); chk("R6 later wake", clk_req, 0);
    stop_req = 0; take(); repeat (3) @(negedge clk);

    // R7 suppressed parity error in snooze
    stop_req = 1; err_quiet = 1; err_irq_en = 1; parity_en = 1; parity_odd = 0;
    repeat (4) @(negedge clk);
    rc0 = rx_cnt; ec0 = er_cnt;
    send(8'hE1, 1, 0);
    chk("R7 snooze mid", mid_snz, 1); chk("R7 flags", flags, 0);
    chk("R7 no rx irq", rx_cnt, rc0); chk("R7 no err irq", er_cnt, ec0);
    chk("R7 not stored", rx_valid, 0); chk("R7 back to stop", clk_req, 0);
    chk("R7 not snoozing", snoozing, 0);
    stop_req = 0; repeat (3) @(negedge clk);
    // R7 suppressed overrun in run mode
    send(8'h44, 0, 0); rc0 = rx_cnt;
    send(8'h55, 0, 0);
    chk("R7 ovr data kept", rx_data, 8'h44); chk("R7 ovr flags", flags, 0);
    chk("R7 ovr no irq", rx_cnt, rc0); take();
    err_quiet = 0; err_irq_en = 0;

    // random frames in run mode
    for (int k = 0; k < 24; k++) begin
      d = 8'($urandom);
      parity_en = 1'($urandom); parity_odd = 1'($urandom);
      send(d, 0, 0);
      chk("R4 random data", rx_data, d); chk("R4 random flags", flags, 0);
      take();
    end

    summary();
    $finish;
  end
endmodule